// File: doc/BRIEF.md
# Oscillator Frequency Calibration Counter

This block measures how fast one clock runs compared with another. Software picks one of four oscillator sources and programs a window length. It then sets a start bit. While the window is open, a down-counter steps once per tick of the selected source. At the same time a 32-bit accumulator counts the cycles in which the divided reference clock pulses. When the down-counter reaches its final tick, the run ends and the start bit clears itself. The accumulated count is then read as two 16-bit halves. Firmware divides the two figures to trim or characterise the oscillator.

The clock sources reach the block as single-cycle, synchronous tick pulses in the system clock domain. The register port is a simple write strobe with a separate read address. Read data is registered. A `busy` level and a one-cycle `done` pulse follow the progress of a run.

Top module: `osc_cal_counter`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every register (control, window length, both result halves) reads 0.
- R2: The control register at address 0 holds the source select in bits [1:0]. Value 0 picks the slow RC oscillator (`src_tick[0]`), 1 the fast RC oscillator (`src_tick[1]`), 2 the slow crystal (`src_tick[2]`) and 3 the external-RC oscillator (`src_tick[3]`).
- R3: A write to address 0 with bit 2 set, accepted while idle, starts a run. `busy` is 1 from the next cycle, and bit 2 of the control register reads 1 while the run lasts.
- R4: In the clock edge that consumes the final selected tick, `busy` falls and `done` pulses high for exactly one cycle. Bit 2 of the control register then reads 0.
- R5: The window length is the 16-bit register at address 1. The down-counter is loaded at start and decrements on each selected tick, ending at 1. A run therefore lasts exactly that many selected ticks, and a length of 0 behaves as 1.
- R6: The result equals the number of cycles with `ref_tick` high, counted from the cycle after the start write up to and including the cycle of the final selected tick.
- R7: The result is read as its low half at address 2 and its high half at address 3. Both halves are read-only, and writes to them are ignored.
- R8: While busy, writes to the control register are ignored: the select is unchanged and the run does not restart. A write with bit 2 clear starts nothing.
- R9: The result is cleared when a run starts. After the run it holds its value, whatever `ref_tick` does, until the next start.
- R10: `rd_data` shows the register addressed by `rd_addr` one clock edge after that address is presented.
- R11: Ticks from sources other than the selected one have no effect on the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Registered read data |
| src_tick | input | 4 | One tick pulse per oscillator source |
| ref_tick | input | 1 | Divided reference clock pulse |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle pulse when a calibration ends |

## Verification
The assertions assume that every tick input is a clean, single-cycle-qualified level, sampled only at the system clock edge. They also assume that reset is held for at least one edge before any register traffic. The stimulus drives all ticks and writes on the falling clock edge, so each pulse is seen by exactly one rising edge.

During runs the unselected sources are held permanently high. This tests the select mux against the noisiest possible neighbours. A control write is also issued during the first cycle of every run, which exercises the busy lockout without ever pushing the window into an undefined state.

// File: rtl/osc_cal_pkg.sv
package osc_cal_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_WINDOW = 2'd1,
    REG_RES_LO = 2'd2,
    REG_RES_HI = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_RC_SLOW   = 2'd0,
    SRC_RC_FAST   = 2'd1,
    SRC_XTAL_SLOW = 2'd2,
    SRC_RC_EXT    = 2'd3
  } src_sel_e;
endpackage

// File: rtl/osc_cal_regs.sv
module osc_cal_regs
  import osc_cal_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int RES_W  = 32,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              busy,
  input  logic [RES_W-1:0]  result,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  win_len,
  output logic              start_req,
  output logic [DATA_W-1:0] rd_data
);
  localparam int START_POS = SEL_W;
  localparam int CTRL_PAD  = DATA_W - SEL_W - 1;

  logic ctrl_wr;
  assign ctrl_wr   = wr_en && (wr_addr == REG_CTRL) && !busy;
  assign start_req = ctrl_wr && wr_data[START_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= '0;
      win_len <= '0;
    end else begin
      if (ctrl_wr)
        sel <= wr_data[SEL_W-1:0];
      if (wr_en && wr_addr == REG_WINDOW)
        win_len <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        REG_CTRL:   rd_data <= {{CTRL_PAD{1'b0}}, busy, sel};
        REG_WINDOW: rd_data <= DATA_W'(win_len);
        REG_RES_LO: rd_data <= result[DATA_W-1:0];
        default:    rd_data <= result[RES_W-1:DATA_W];
      endcase
    end
  end
endmodule

// File: rtl/osc_cal_window.sv
module osc_cal_window #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_len,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= (load_len == '0) ? ONE : load_len;
      end else if (busy && tick) begin
        if (cnt == ONE) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/osc_cal_accum.sv
module osc_cal_accum #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic             ref_tick,
  output logic [RES_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      count <= '0;
    else if (enable && ref_tick)
      count <= count + RES_W'(1);
  end
endmodule

// File: rtl/osc_cal_counter.sv
module osc_cal_counter
  import osc_cal_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [1:0]         rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ref_tick,
  output logic               busy,
  output logic               done
);
  localparam int SEL_W = $clog2(NUM_SRC);
  localparam int RES_W = 2 * DATA_W;

  logic [SEL_W-1:0]   sel_q;
  logic [CNT_W-1:0]   win_len;
  logic [CNT_W-1:0]   win_cnt;
  logic [RES_W-1:0]   res_cnt;
  logic               start_req;
  logic [NUM_SRC-1:0] src_hit;
  logic               sel_tick;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_hit[i] = src_tick[i] && (sel_q == SEL_W'(i));
  end
  assign sel_tick = |src_hit;

  osc_cal_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .RES_W(RES_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .busy(busy), .result(res_cnt),
    .sel(sel_q), .win_len(win_len), .start_req(start_req), .rd_data(rd_data)
  );

  osc_cal_window #(.CNT_W(CNT_W)) u_window (
    .clk(clk), .rst(rst), .start(start_req), .load_len(win_len),
    .tick(sel_tick), .busy(busy), .done(done), .cnt(win_cnt)
  );

  osc_cal_accum #(.RES_W(RES_W)) u_accum (
    .clk(clk), .rst(rst), .clear(start_req), .enable(busy),
    .ref_tick(ref_tick), .count(res_cnt)
  );
endmodule

// File: rtl/osc_cal_counter_check.sv
module osc_cal_counter_check #(
  parameter int CNT_W = 16,
  parameter int RES_W = 32,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             start_req,
  input logic [SEL_W-1:0] sel,
  input logic [CNT_W-1:0] win_cnt,
  input logic [RES_W-1:0] result
);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start_req |=> busy);
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_window_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (win_cnt != '0));
  assert_sel_held_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(sel));
  assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_req) |=> $stable(result));
endmodule

bind osc_cal_counter osc_cal_counter_check #(
  .CNT_W(CNT_W), .RES_W(RES_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .start_req(start_req),
  .sel(sel_q), .win_cnt(win_cnt), .result(res_cnt)
);

// File: tb/osc_cal_counter_test.sv
`timescale 1ns/1ps
module osc_cal_counter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  src_tick = '0;
  logic        ref_tick = 1'b0;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  osc_cal_counter uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_tick(src_tick),
    .ref_tick(ref_tick), .busy(busy), .done(done)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_cal(input int s, input int len, input int sp, input int rq, input int ph);
    int eff;
    int rem;
    int c;
    longint exp_cnt;
    logic [15:0] v;
    logic st;
    eff = (len == 0) ? 1 : len;
    rem = eff;
    c = 0;
    exp_cnt = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'(len);
    @(negedge clk);
    wr_addr = 2'd0; wr_data = 16'h0004 | 16'(s);
    @(negedge clk);
    chk("R3 busy after start", busy, 1);
    // R8: attempt to change select and restart while busy
    wr_addr = 2'd0; wr_data = 16'h0004 | 16'((s + 1) % 4);
    while (rem > 0) begin
      c++;
      st = (c % sp) == 0;
      src_tick = 4'hF & ~(4'b1 << s);   // R11: other sources always ticking
      if (st) src_tick[s] = 1'b1;
      ref_tick = ((c + ph) % rq) == 0;
      if (ref_tick) exp_cnt++;
      if (st) rem--;
      @(negedge clk);
      wr_en = 1'b0;
    end
    src_tick = '0; ref_tick = 1'b0;
    chk("R4 done pulse at end", done, 1);
    chk("R5 busy falls after window", busy, 0);
    read_reg(2'd2, v);
    chk("R4 done lasts one cycle", done, 0);
    chk("R6 result low half", v, exp_cnt & 16'hFFFF);
    read_reg(2'd3, v);
    chk("R7 result high half", v, exp_cnt >> 16);
    read_reg(2'd0, v);
    chk("R8 ctrl: start cleared, select kept", v, s);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy at reset", busy, 0);
    chk("R1 done at reset", done, 0);
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), v);
      chk("R1 register reset value", v, 0);
    end

    // R8: write without start bit
    wr(2'd0, 16'h0002);
    chk("R8 no start without bit 2", busy, 0);
    read_reg(2'd0, v);
    chk("R2 select readback", v, 2);
    // R10: registered read latency
    wr(2'd1, 16'h1234);
    rd_addr = 2'd1;
    #1;
    chk("R10 read data not yet updated", rd_data, 2);
    @(negedge clk);
    chk("R10 read data after one edge", rd_data, 16'h1234);

    run_cal(1, 3, 1, 1, 0);
    // R7: writes to result halves ignored
    read_reg(2'd2, held);
    wr(2'd2, 16'hBEEF);
    wr(2'd3, 16'hBEEF);
    read_reg(2'd2, v);
    chk("R7 low half read-only", v, held);
    read_reg(2'd3, v);
    chk("R7 high half read-only", v, 0);
    // R9: idle reference ticks do not change the result
    ref_tick = 1'b1;
    repeat (5) @(negedge clk);
    ref_tick = 1'b0;
    read_reg(2'd2, v);
    chk("R9 result held when idle", v, held);

    // sweep: R2 R5 R6 R11 across sources, lengths and tick spacings
    for (int s = 0; s < 4; s++)
      for (int li = 0; li < 5; li++)
        for (int sp = 1; sp <= 3; sp++)
          for (int rq = 1; rq <= 3; rq++) begin
            int lens[5] = '{0, 1, 2, 3, 6};
            run_cal(s, lens[li], sp, rq, s);
          end

    // R9: a new start clears the previous result; long run crosses 16 bits
    run_cal(1, 1, 70000, 1, 0);
    run_cal(2, 1, 1, 2, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule